// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Enable Logic

This block holds the interrupt status byte and the interrupt enable byte of a real-time clock. Three event pulses arrive from elsewhere in the clock: a periodic tick, an alarm match and an end-of-update event. Each pulse leaves a sticky flag in the status byte. A summary request bit is raised, and with it the interrupt line, when an event meets its enable.

Software clears the status byte by reading it. Turning an enable on for a flag that is already pending requests an interrupt at once. The periodic flag records every tick, even while its interrupt is masked.

Bus decoding lives outside the block. The block receives a write strobe with a register select and data, a read strobe with a register select, and returns registered read data one cycle after the strobe.

Top module: `rtc_irq_flags`

## Requirements
- R1: Status byte layout: bit 7 is the summary request, bit 6 the periodic flag, bit 5 the alarm flag, bit 4 the update flag, and bits 3..0 read as 0. The control byte uses bit 6 for the periodic enable, bit 5 for the alarm enable and bit 4 for the update enable. Register selects: 1 is control, 2 is status, 3 is the fixed auxiliary byte, and 0 reads as 0.
- R2: A periodic pulse always sets the periodic flag. It sets the summary bit, which raises the interrupt, only when the periodic enable is 1. This also happens when the periodic flag is already set.
- R3: An alarm or update pulse raises the summary bit only if its flag was clear before the pulse and its enable is 1. A pulse that finds its flag already set leaves the summary bit unchanged.
- R4: A status read returns the byte as it was before the read, and clears the whole byte. The interrupt is low in the cycle after the read.
- R5: A control write sets the summary bit in the next cycle if the written enables overlap a pending flag. Otherwise it clears the summary bit.
- R6: Writes to select 2 and select 3 change nothing. Select 3 always reads 0x80.
- R7: Reset puts 0x02 in the control byte, so the periodic enable, the alarm enable and the square-wave enable (bit 3) are 0. Reset clears the status byte and drives the interrupt low.
- R8: An event in the same cycle as a status read survives the clear. Its raise rule is evaluated against the cleared byte.
- R9: The interrupt output equals status bit 7 in every cycle.
- R10: A control write with bit 7 (update freeze) set stores the update enable as 0.
- R11: Read data is registered and appears in the cycle after the read strobe. The control byte reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | End-of-update pulse |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- a periodic or alarm pulse always leaves its flag set;
- a status read with no coinciding event leaves the byte clear;
- writes to the status or auxiliary select leave the byte unchanged;
- a repeated alarm pulse does not change the request;
- an overlapping control write raises the request;
- the freeze bit masks the update enable;
- reset takes effect.

Other behaviour needs the bench's ordered scenarios:
- whether a read returns the value from before its own clear;
- that a masked flag becomes an interrupt only once its enable is written;
- that a control write drops a pending request;
- the exact byte values produced by mixed event histories.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_AUX  = 2'd3
  } reg_sel_e;

  // Source indices within the flag/enable field.
  localparam int NSRC    = 3;
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;

  // Bit positions shared by the status and control bytes.
  localparam int SRC_LSB    = 4;
  localparam int BIT_SUM    = 7;
  localparam int BIT_FREEZE = 7;
  localparam int BIT_SQW    = 3;
  localparam int BYTE_W     = 8;

endpackage

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
  import rtc_irq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CTL_RESET = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [NSRC-1:0]   en_next
);

  localparam logic [BYTE_W-1:0] RST_CLR =
    (BYTE_W'(1) << (SRC_LSB + SRC_PER)) |
    (BYTE_W'(1) << (SRC_LSB + SRC_ALM)) |
    (BYTE_W'(1) << BIT_SQW);

  logic [BYTE_W-1:0] wmasked;
  logic [BYTE_W-1:0] ctl_d;

  // The freeze bit suppresses the update enable on the same write.
  always_comb begin
    wmasked = wdata;
    if (wdata[BIT_FREEZE]) begin
      wmasked[SRC_LSB + SRC_UPD] = 1'b0;
    end
  end

  assign ctl_d   = wr ? wmasked : ctl_q;
  assign en_next = ctl_d[SRC_LSB +: NSRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET & ~RST_CLR;
    end else begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/rtc_src_flag.sv
module rtc_src_flag #(
  parameter bit ALWAYS_RAISE = 1'b0
) (
  input  logic evt,
  input  logic flag_base,
  input  logic en,
  output logic flag_next,
  output logic raise
);

  assign flag_next = flag_base | evt;

  generate
    if (ALWAYS_RAISE) begin : g_tick
      // Every tick requests an interrupt when enabled.
      assign raise = evt & en;
    end else begin : g_edge
      // Only a clear-to-set transition requests an interrupt.
      assign raise = evt & ~flag_base & en;
    end
  endgenerate

endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_clr,
  input  logic              ctl_wr,
  input  logic [NSRC-1:0]   en_next,
  input  logic [NSRC-1:0]   evt,
  output logic [BYTE_W-1:0] stat_q
);

  logic [NSRC-1:0]   flags_base;
  logic [NSRC-1:0]   flags_next;
  logic [NSRC-1:0]   raise;
  logic              sum_base;
  logic              sum_mid;
  logic              sum_next;
  logic [BYTE_W-1:0] stat_d;

  assign flags_base = rd_clr ? '0 : stat_q[SRC_LSB +: NSRC];
  assign sum_base   = rd_clr ? 1'b0 : stat_q[BIT_SUM];

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      rtc_src_flag #(
        .ALWAYS_RAISE(i == SRC_PER)
      ) u_flag (
        .evt       (evt[i]),
        .flag_base (flags_base[i]),
        .en        (en_next[i]),
        .flag_next (flags_next[i]),
        .raise     (raise[i])
      );
    end
  endgenerate

  // A control write re-evaluates the request against pending flags.
  assign sum_mid  = ctl_wr ? |(en_next & flags_base) : sum_base;
  assign sum_next = sum_mid | (|raise);

  always_comb begin
    stat_d                     = '0;
    stat_d[BIT_SUM]            = sum_next;
    stat_d[SRC_LSB +: NSRC]    = flags_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/rtc_rd_port.sv
module rtc_rd_port
  import rtc_irq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] AUX_VALUE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  input  logic [BYTE_W-1:0] ctl_q,
  input  logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] rd_data
);

  logic [BYTE_W-1:0] mux;

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_CTL:  mux = ctl_q;
      SEL_STAT: mux = stat_q;
      SEL_AUX:  mux = AUX_VALUE;
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= mux;
    end
  end

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
#(
  parameter logic [7:0] CTL_RESET = 8'h02,
  parameter logic [7:0] AUX_VALUE = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       irq
);

  logic              ctl_wr;
  logic              rd_clr;
  logic [NSRC-1:0]   evt;
  logic [NSRC-1:0]   en_next;
  logic [BYTE_W-1:0] ctl_q;
  logic [BYTE_W-1:0] stat_q;

  assign ctl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
  assign rd_clr = rd_en && (reg_sel_e'(rd_sel) == SEL_STAT);

  always_comb begin
    evt          = '0;
    evt[SRC_PER] = evt_periodic;
    evt[SRC_ALM] = evt_alarm;
    evt[SRC_UPD] = evt_update;
  end

  rtc_ctl_reg #(
    .CTL_RESET(CTL_RESET)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr      (ctl_wr),
    .wdata   (wr_data),
    .ctl_q   (ctl_q),
    .en_next (en_next)
  );

  rtc_status_reg u_stat (
    .clk     (clk),
    .rst     (rst),
    .rd_clr  (rd_clr),
    .ctl_wr  (ctl_wr),
    .en_next (en_next),
    .evt     (evt),
    .stat_q  (stat_q)
  );

  rtc_rd_port #(
    .AUX_VALUE(AUX_VALUE)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .ctl_q   (ctl_q),
    .stat_q  (stat_q),
    .rd_data (rd_data)
  );

  assign irq = stat_q[BIT_SUM];

endmodule

// File: rtl/rtc_irq_flags_chk.sv
module rtc_irq_flags_chk #(
  parameter logic [7:0] CTL_RESET = 8'h02
) (
  input logic       clk,
  input logic       rst,
  input logic       evt_periodic,
  input logic       evt_alarm,
  input logic       evt_update,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [1:0] rd_sel,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic [7:0] stat_q,
  input logic [7:0] ctl_q
);

  logic rd_stat;
  logic wr_ctl;
  logic any_evt;

  assign rd_stat = rd_en && (rd_sel == 2'd2);
  assign wr_ctl  = wr_en && (wr_sel == 2'd1);
  assign any_evt = evt_periodic | evt_alarm | evt_update;

  // R7
  a_r7_reset_state: assert property (@(posedge clk)
    rst |=> (!irq && stat_q == 8'h00 && ctl_q == (CTL_RESET & 8'h97)));

  // R2
  a_r2_tick_sets_flag: assert property (@(posedge clk) disable iff (rst)
    evt_periodic |=> stat_q[6]);

  // R8
  a_r8_alarm_survives: assert property (@(posedge clk) disable iff (rst)
    evt_alarm |=> stat_q[5]);

  // R4
  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !any_evt && !wr_ctl) |=> (stat_q == 8'h00 && !irq));

  // R9
  a_r9_readback_matches_irq: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (rd_data[7] == $past(irq)));

  // R6
  a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel != 2'd1 && !rd_stat && !any_evt) |=> $stable(stat_q));

  // R3
  a_r3_repeat_alarm_no_change: assert property (@(posedge clk) disable iff (rst)
    (evt_alarm && stat_q[5] && !evt_periodic && !evt_update && !wr_ctl && !rd_stat)
      |=> (irq == $past(irq)));

  // R5
  a_r5_enable_pending_raises: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !rd_stat && !wr_data[7] && ((wr_data & stat_q & 8'h70) != 8'h00))
      |=> irq);

  // R10
  a_r10_freeze_masks_update: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wr_data[7]) |=> !ctl_q[4]);

endmodule

bind rtc_irq_flags rtc_irq_flags_chk #(
  .CTL_RESET(CTL_RESET)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .evt_periodic (evt_periodic),
  .evt_alarm    (evt_alarm),
  .evt_update   (evt_update),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .rd_en        (rd_en),
  .rd_sel       (rd_sel),
  .rd_data      (rd_data),
  .irq          (irq),
  .stat_q       (stat_q),
  .ctl_q        (ctl_q)
);

// File: tb/test_rtc_irq_flags.sv
module test_rtc_irq_flags;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_periodic = 1'b0;
  logic       evt_alarm = 1'b0;
  logic       evt_update = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       irq;

  localparam logic [1:0] CTL = 2'd1;
  localparam logic [1:0] STA = 2'd2;
  localparam logic [1:0] AUX = 2'd3;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic rd_seen = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  rtc_irq_flags i_rtc_irq_flags (
    .clk          (clk),
    .rst          (rst),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .rd_en        (rd_en),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .irq          (irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: read data lands one cycle after the strobe.
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("scoreboard-underflow", rd_data, 8'hxx);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic cyc(input logic p, input logic a, input logic u,
                     input logic w, input logic [1:0] ws, input logic [7:0] wd,
                     input logic r, input logic [1:0] rs,
                     input logic [7:0] rexp, input string tag);
    @(negedge clk);
    evt_periodic = p; evt_alarm = a; evt_update = u;
    wr_en = w; wr_sel = ws; wr_data = wd;
    rd_en = r; rd_sel = rs;
    if (r) begin
      exp_q.push_back(rexp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ev(input logic p, input logic a, input logic u);
    cyc(p, a, u, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "");
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, s, d, 1'b0, 2'd0, 8'h00, "");
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] e, input string tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b1, s, e, tag);
  endtask

  task automatic irq_is(input logic e, input string tag);
    check(tag, {7'd0, irq}, {7'd0, e});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    irq_is(1'b0, "R7 irq low after reset");
    rd(STA, 8'h00, "R7 status cleared");
    rd(CTL, 8'h02, "R7 control reset value");
    rd(AUX, 8'h80, "R6 aux byte");
    rd(2'd0, 8'h00, "R1 select 0 reads zero");

    // Periodic tick while masked.
    ev(1'b1, 1'b0, 1'b0);
    irq_is(1'b0, "R2 masked tick no irq");
    rd(STA, 8'h40, "R2 PF set while masked");
    irq_is(1'b0, "R4 irq low after read");
    rd(STA, 8'h00, "R4 cleared by read");

    // Periodic enabled.
    wr(CTL, 8'h42);
    irq_is(1'b0, "R5 no pending flag clears request");
    rd(CTL, 8'h42, "R11 control readback");
    ev(1'b1, 1'b0, 1'b0);
    irq_is(1'b1, "R2 enabled tick raises");
    rd(STA, 8'hC0, "R1 R9 summary and PF");
    irq_is(1'b0, "R4 read drops irq");
    ev(1'b1, 1'b0, 1'b0);
    ev(1'b1, 1'b0, 1'b0);
    irq_is(1'b1, "R2 repeat tick");
    rd(STA, 8'hC0, "R2 repeat tick status");

    // Alarm masked then enabled with flag pending.
    ev(1'b0, 1'b1, 1'b0);
    irq_is(1'b0, "R3 masked alarm");
    ev(1'b0, 1'b1, 1'b0);
    irq_is(1'b0, "R3 repeated masked alarm");
    wr(CTL, 8'h62);
    irq_is(1'b1, "R5 enable on pending raises");
    rd(STA, 8'hA0, "R5 status after enable");

    // Enabled alarm, then write that masks it.
    ev(1'b0, 1'b1, 1'b0);
    irq_is(1'b1, "R3 new alarm flag raises");
    wr(CTL, 8'h42);
    irq_is(1'b0, "R5 write without overlap clears");
    rd(STA, 8'h20, "R5 flag kept summary cleared");

    // Update event.
    wr(CTL, 8'h12);
    ev(1'b0, 1'b0, 1'b1);
    irq_is(1'b1, "R3 update raises");

    // Ignored writes.
    wr(STA, 8'h00);
    irq_is(1'b1, "R6 status write ignored");
    wr(AUX, 8'hFF);
    rd(AUX, 8'h80, "R6 aux write ignored");
    rd(STA, 8'h90, "R6 status intact");

    // Event coinciding with a status read.
    ev(1'b1, 1'b0, 1'b0);
    irq_is(1'b0, "R2 tick masked under UIE-only");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, STA, 8'h40, "R8 read returns pre-clear");
    irq_is(1'b1, "R8 event survives read");
    rd(STA, 8'h90, "R8 surviving flag");

    // Freeze bit masks update enable.
    wr(CTL, 8'h92);
    rd(CTL, 8'h82, "R10 update enable masked");
    ev(1'b0, 1'b0, 1'b1);
    irq_is(1'b0, "R10 update no irq");
    rd(STA, 8'h10, "R10 UF only");

    // Reset in mid-run.
    wr(CTL, 8'h7A);
    ev(1'b1, 1'b0, 1'b0);
    irq_is(1'b1, "R2 tick before reset");
    do_reset();
    irq_is(1'b0, "R7 reset drops irq");
    rd(CTL, 8'h02, "R7 enables cleared");
    rd(STA, 8'h00, "R7 status cleared");

    repeat (3) @(negedge clk);
    check("scoreboard-drain", 8'(exp_q.size()), 8'h00);
    finish_run();
  end

endmodule